// File: doc/BRIEF.md
# Per-Bit Trigger Condition Evaluator

This block decides, sample by sample, whether a set of probed signals meets a trigger condition. Each probed bit carries its own 3-bit condition code. The code selects one of six tests: ignore the bit, require it low, require it high, or require a rising, falling or any edge. Edge tests compare the current sample with the sample kept from the previous accepted strobe. All per-bit results are combined with a logical AND, and a bit set to ignore contributes a constant pass.

The surrounding capture logic pulses `arm` to start a new search. This clears the stored history. After that, it presents a sample vector with `smp_vld` on every sample-clock rising edge it wants evaluated. When every condition holds on an evaluated sample, `hit` is high for exactly one cycle, in the cycle after that sample. Samples taken while the block is unarmed, in the `arm` cycle itself, or without `smp_vld` are not evaluated and are not stored as history.

Top module: `trig_eval_top`

## Requirements
- R1: After reset the block is unarmed and `hit` is 0. No sample is evaluated until `arm` has been pulsed.
- R2: A bit with code 0 (ignore) never affects the result. If every bit has code 0, each evaluated sample hits, including the first sample after arming.
- R3: Code 1 passes when the current bit is 0, and code 2 passes when the current bit is 1. The previous sample plays no part in either test.
- R4: Code 3 passes when the previous stored bit is 0 and the current bit is 1.
- R5: Code 4 passes when the previous stored bit is 1 and the current bit is 0.
- R6: Code 5 passes when the previous stored bit differs from the current bit.
- R7: On the first evaluated sample after `arm`, every edge code (3, 4, 5) fails, because no previous sample exists yet.
- R8: `hit` is the AND of all per-bit results. One failing bit blocks the hit.
- R9: A bus given code 2 on every bit hits only when all of its bits are 1 at once.
- R10: Suppose bit 0 has code 4 and bit 1 has code 5. With the sequence {1,1} then {0,0}, the block hits on the second sample and not on the first.
- R11: A cycle with `smp_vld` low neither evaluates nor updates the stored previous sample.
- R12: Codes 6 and 7 behave as ignore.
- R13: `hit` is a single-cycle pulse, one cycle after an evaluated sample that matched. The sample presented in the `arm` cycle is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock; all state changes on its rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| arm | input | 1 | Pulse that starts a search and clears the sample history |
| smp_vld | input | 1 | Marks the current sample for evaluation |
| smp_data | input | NBITS | Current sample of the probed signals |
| cond_codes | input | NBITS*3 | Condition code per bit; bit i uses bits [3i+2:3i] |
| hit | output | 1 | One-cycle pulse when all conditions held on the last evaluated sample |

## Verification
The bench checks the first sample after arming. A design that forgot to invalidate the history would fire edge conditions there, using data left over from an earlier search. It inserts idle cycles with changing data between strobes. A design that updated its history on every clock would then lose an edge or invent one. It replays the two-signal sequence of falling edge with any change, where an OR combination or an off-by-one history would fire on the earlier sample. It also sweeps the reserved codes and all-ignore vectors, where a decoder with a wrong default would block hits that should pass.

// File: rtl/trig_pkg.sv
package trig_pkg;
  localparam int CODE_W = 3;

  typedef enum logic [CODE_W-1:0] {
    CND_ANY  = 3'd0,
    CND_LOW  = 3'd1,
    CND_HIGH = 3'd2,
    CND_RISE = 3'd3,
    CND_FALL = 3'd4,
    CND_CHG  = 3'd5
  } cond_e;

  // Test of one bit against its code; reserved codes pass.
  function automatic logic bit_pass(logic [CODE_W-1:0] code, logic cur,
                                    logic prv, logic prv_ok);
    logic r;
    case (code)
      CND_LOW:  r = ~cur;
      CND_HIGH: r = cur;
      CND_RISE: r = prv_ok & ~prv & cur;
      CND_FALL: r = prv_ok & prv & ~cur;
      CND_CHG:  r = prv_ok & (prv ^ cur);
      default:  r = 1'b1;
    endcase
    return r;
  endfunction

  function automatic logic is_edge_code(logic [CODE_W-1:0] code);
    return (code == CND_RISE) || (code == CND_FALL) || (code == CND_CHG);
  endfunction
endpackage

// File: rtl/trig_history.sv
module trig_history #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         load,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout,
  output logic         valid
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dout  <= '0;
      valid <= 1'b0;
    end else if (clr) begin
      valid <= 1'b0;
    end else if (load) begin
      dout  <= din;
      valid <= 1'b1;
    end
  end
endmodule

// File: rtl/trig_bit_cell.sv
module trig_bit_cell
  import trig_pkg::*;
(
  input  logic [CODE_W-1:0] code,
  input  logic              cur,
  input  logic              prv,
  input  logic              prv_ok,
  output logic              pass
);
  always_comb pass = bit_pass(code, cur, prv, prv_ok);
endmodule

// File: rtl/trig_eval_top.sv
module trig_eval_top
  import trig_pkg::*;
#(
  parameter int NBITS = 8,
  localparam int CW   = NBITS * CODE_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             arm,
  input  logic             smp_vld,
  input  logic [NBITS-1:0] smp_data,
  input  logic [CW-1:0]    cond_codes,
  output logic             hit
);
  logic             armed;
  logic             eval_now;
  logic             prev_ok;
  logic [NBITS-1:0] prev_smp;
  logic [NBITS-1:0] pass_vec;
  logic             all_match;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed <= 1'b0;
    else if (arm) armed <= 1'b1;
  end

  assign eval_now = armed & smp_vld & ~arm;

  trig_history #(.W(NBITS)) u_hist (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (arm),
    .load  (eval_now),
    .din   (smp_data),
    .dout  (prev_smp),
    .valid (prev_ok)
  );

  for (genvar i = 0; i < NBITS; i++) begin : g_cell
    trig_bit_cell u_cell (
      .code   (cond_codes[i*CODE_W +: CODE_W]),
      .cur    (smp_data[i]),
      .prv    (prev_smp[i]),
      .prv_ok (prev_ok),
      .pass   (pass_vec[i])
    );
  end

  assign all_match = &pass_vec;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hit <= 1'b0;
    else        hit <= eval_now & all_match;
  end
endmodule

// File: rtl/trig_eval_chk.sv
module trig_eval_chk
  import trig_pkg::*;
#(
  parameter int NBITS = 8,
  localparam int CW   = NBITS * CODE_W
) (
  input logic             clk,
  input logic             rst_n,
  input logic             arm,
  input logic             armed,
  input logic             eval_now,
  input logic             prev_ok,
  input logic [CW-1:0]    cond_codes,
  input logic             hit
);
  logic any_edge, all_ign;
  always_comb begin
    any_edge = 1'b0;
    all_ign  = 1'b1;
    for (int i = 0; i < NBITS; i++) begin
      if (is_edge_code(cond_codes[i*CODE_W +: CODE_W])) any_edge = 1'b1;
      if (cond_codes[i*CODE_W +: CODE_W] != CND_ANY) all_ign = 1'b0;
    end
  end

  // R13
  hit_after_eval_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> $past(eval_now));
  // R13
  no_hit_after_arm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(arm) |-> !hit);
  // R1
  unarmed_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !armed |=> !hit);
  // R7
  first_edge_blocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (eval_now && !prev_ok && any_edge) |=> !hit);
  // R2
  all_ignore_hits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (eval_now && all_ign) |=> hit);
  // R11
  history_loaded_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eval_now |=> prev_ok);
endmodule

bind trig_eval_top trig_eval_chk #(.NBITS(NBITS)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .arm        (arm),
  .armed      (armed),
  .eval_now   (eval_now),
  .prev_ok    (prev_ok),
  .cond_codes (cond_codes),
  .hit        (hit)
);

// File: tb/sim_trig_eval_top.sv
`timescale 1ns/1ps
module sim_trig_eval_top;
  localparam int N = 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         arm = 1'b0;
  logic         smp_vld = 1'b0;
  logic [N-1:0] smp_data = '0;
  logic [N*3-1:0] cond_codes = '0;
  logic         hit;

  always #5 clk = ~clk;

  trig_eval_top #(.NBITS(N)) u0 (
    .clk(clk), .rst_n(rst_n), .arm(arm), .smp_vld(smp_vld),
    .smp_data(smp_data), .cond_codes(cond_codes), .hit(hit)
  );

  int compared = 0;
  int mismatched = 0;
  string tag = "R1";

  // behavioural model state
  bit           m_armed = 0;
  bit           m_pv = 0;
  bit [N-1:0]   m_prev = '0;
  bit           exp_hit = 0;

  function automatic bit model_eval(bit [N*3-1:0] cc, bit [N-1:0] d,
                                    bit [N-1:0] p, bit pv);
    bit ok = 1;
    for (int i = 0; i < N; i++) begin
      int c = int'(cc[i*3 +: 3]);
      if (c == 1 && d[i] != 0) ok = 0;
      if (c == 2 && d[i] != 1) ok = 0;
      if (c == 3 && !(pv && p[i] == 0 && d[i] == 1)) ok = 0;
      if (c == 4 && !(pv && p[i] == 1 && d[i] == 0)) ok = 0;
      if (c == 5 && !(pv && p[i] != d[i])) ok = 0;
    end
    return ok;
  endfunction

  // one clock: compare last result, drive new inputs, advance model
  task automatic step(input bit a, input bit v, input bit [N-1:0] d,
                      input bit [N*3-1:0] cc);
    @(negedge clk);
    compared++;
    if (hit !== exp_hit) begin
      mismatched++;
      $display("FAIL %s: hit actual=%0b expected=%0b at %0t", tag, hit, exp_hit, $time);
    end
    arm = a; smp_vld = v; smp_data = d; cond_codes = cc;
    exp_hit = 0;
    if (a) begin
      m_armed = 1; m_pv = 0;
    end else if (m_armed && v) begin
      exp_hit = model_eval(cc, d, m_prev, m_pv);
      m_prev = d; m_pv = 1;
    end
  endtask

  function automatic bit [N*3-1:0] codes1(int b, int c);
    bit [N*3-1:0] r = '0;
    r[b*3 +: 3] = 3'(c);
    return r;
  endfunction

  bit [N*3-1:0] cc;

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: unarmed, samples ignored even with all-ignore codes
    tag = "R1";
    step(0, 1, 8'hFF, '0);
    step(0, 1, 8'h00, '0);
    step(0, 0, 8'h00, '0);
    // R13: sample in arm cycle discarded; R2 all-ignore hits on first sample
    tag = "R13";
    step(1, 1, 8'hAA, '0);
    tag = "R2";
    step(0, 1, 8'h12, '0);
    step(0, 1, 8'h34, '0);
    step(0, 0, 8'h34, '0);
    // R3 levels
    tag = "R3";
    cc = codes1(0, 1) | codes1(5, 2);
    step(0, 1, 8'h20, cc);
    step(0, 1, 8'h21, cc);
    step(0, 1, 8'h00, cc);
    step(0, 1, 8'hDE, cc);
    // R7 edge on first sample after re-arm
    tag = "R7";
    step(1, 0, 8'h00, cc);
    step(0, 1, 8'h01, codes1(0, 3));
    step(1, 0, 8'h00, '0);
    step(0, 1, 8'h00, codes1(1, 5));
    step(1, 0, 8'hFF, '0);
    step(0, 1, 8'h00, codes1(2, 4));
    // R4 rising
    tag = "R4";
    cc = codes1(3, 3);
    step(0, 1, 8'h00, cc);
    step(0, 1, 8'h08, cc);
    step(0, 1, 8'h08, cc);
    step(0, 1, 8'h00, cc);
    // R5 falling
    tag = "R5";
    cc = codes1(7, 4);
    step(0, 1, 8'h80, cc);
    step(0, 1, 8'h00, cc);
    step(0, 1, 8'h00, cc);
    step(0, 1, 8'h80, cc);
    // R6 either
    tag = "R6";
    cc = codes1(4, 5);
    step(0, 1, 8'h00, cc);
    step(0, 1, 8'h10, cc);
    step(0, 1, 8'h10, cc);
    step(0, 1, 8'h00, cc);
    // R11 gaps without strobe do not update history
    tag = "R11";
    cc = codes1(0, 3);
    step(0, 1, 8'h00, cc);
    step(0, 0, 8'h01, cc);
    step(0, 0, 8'h00, cc);
    step(0, 1, 8'h01, cc);
    step(0, 0, 8'h00, cc);
    step(0, 1, 8'h01, cc);
    // R8 AND combination
    tag = "R8";
    cc = codes1(0, 3) | codes1(1, 2) | codes1(2, 1);
    step(0, 1, 8'h00, cc);
    step(0, 1, 8'h07, cc);
    step(0, 1, 8'h00, cc);
    step(0, 1, 8'h03, cc);
    // R9 4-bit bus all high
    tag = "R9";
    cc = codes1(4, 2) | codes1(5, 2) | codes1(6, 2) | codes1(7, 2);
    step(0, 1, 8'h70, cc);
    step(0, 1, 8'hF0, cc);
    step(0, 1, 8'hB3, cc);
    step(0, 1, 8'hFF, cc);
    // R10 falling on bit0 with any change on bit1
    tag = "R10";
    cc = codes1(0, 4) | codes1(1, 5);
    step(1, 0, 8'h00, cc);
    step(0, 1, 8'h03, cc);
    step(0, 1, 8'h03, cc);
    step(0, 1, 8'h00, cc);
    step(0, 1, 8'h00, cc);
    // R12 reserved codes
    tag = "R12";
    cc = codes1(0, 6) | codes1(3, 7) | codes1(6, 6);
    step(0, 1, 8'h49, cc);
    step(0, 1, 8'h00, cc);
    cc = {N{3'd7}};
    step(0, 1, 8'h5A, cc);
    // patterned sweep over all codes
    tag = "R8";
    for (int k = 0; k < 60; k++) begin
      bit [N*3-1:0] c2 = '0;
      for (int i = 0; i < N; i++) c2[i*3 +: 3] = 3'(((k + i*3) % 8 < 6) ? 0 : (k + i) % 6);
      step((k % 17) == 0, (k % 5) != 3, 8'((k * 37) ^ (k >> 1)), c2);
    end
    tag = "R13";
    step(0, 0, 8'h00, '0);
    step(0, 0, 8'h00, '0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    #200000;
    mismatched++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule